// File: doc/BRIEF.md
# SDI Sync and Line Number Embedder

This block sits between a video timing generator and an SDI transmitter. It receives one or more lanes of 10-bit YCbCr words together with separate horizontal-blank, vertical-blank and field strobes. It produces the same lanes with the timing carried in-band. The sample where horizontal blanking starts, and the three samples after it, become an end-of-active-video timing reference. The four samples just before the first active sample of each line become a start-of-active-video reference. In HD operation, the two samples after the end reference carry an encoded line number.

A line counter advances at every end-of-active-video reference and returns to 1 at the first line of a frame. In progressive operation, any rise of vertical blank marks the first line. In interlaced operation, only a vertical-blank rise that comes with or after a fall of the field flag to 0 marks it. Inserted words replace blanking samples, so the number of samples per line never changes and every sample leaves the block exactly five clocks after it enters. All lanes receive the same inserted words.

Top module: `sle_embedder`

## Requirements
- R1: A sample that is not replaced leaves on every lane unchanged, 5 clock edges after the edge that captured it.
- R2: At a rise of horizontal blank (blank now 1, previous sample 0), that sample and the next three become 0x3FF, 0x000, 0x000 and a reference word with H=1, on every lane.
- R3: A reference word has bit 9 = 1, bit 8 = F, bit 7 = V, bit 6 = H, bits 5..2 = V^H, F^H, F^V, F^V^H, and bits 1..0 = 0. For an end reference, F and V come from the first blanking sample. For a start reference, they come from the first active sample.
- R4: The four samples just before the first active sample (horizontal blank now 0, previous sample 1) become 0x3FF, 0x000, 0x000 and a reference word with H=0, on every lane.
- R5: With hd_mode=1, the two samples after an end reference carry the line number L. The first is {~L[6], L[6:0], 2'b00}. The second is {1'b1, 3'b000, L[10:7], 2'b00}. With hd_mode=0, those samples pass through unchanged.
- R6: The line number advances by 1, modulo 2048, at each end reference. The value embedded after that reference is the advanced value. After reset, the count is 0.
- R7: With interlaced=0, a rise of vertical blank at any sample since the previous end reference, or at the same sample as the current one, makes the current end reference carry line 1.
- R8: With interlaced=1, a rise of vertical blank restarts the count at 1 only if the field flag has fallen from 1 to 0 since the last restart, at or before that rise. Other rises continue the count.
- R9: While reset is held, all data outputs and both marker outputs are 0.
- R10: vout_eav (or vout_sav) is 1 in exactly the cycle in which the end (or start) reference word is on the output. The two markers are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| interlaced | input | 1 | 1 selects interlaced frame detection |
| hd_mode | input | 1 | 1 enables line-number words after end references |
| vin_data | input | LANES*10 | Input video lanes, lane 0 in the low bits |
| vin_hblank | input | 1 | Horizontal blanking strobe |
| vin_vblank | input | 1 | Vertical blanking strobe |
| vin_field | input | 1 | Field flag |
| vout_data | output | LANES*10 | Output lanes with embedded timing |
| vout_eav | output | 1 | Marks the end reference word on the output |
| vout_sav | output | 1 | Marks the start reference word on the output |

## Verification
The assertions assume that horizontal blanking lasts at least ten samples, so that an end sequence with its line words never overlaps the start sequence that follows. They also assume that each active period has at least one sample, and that hd_mode and interlaced stay fixed between resets. The stimulus builds whole lines whose blanking and active lengths meet these limits. It changes the mode inputs only while reset is held, and it places field and vertical-blank changes at line starts, except for one deliberate mid-line vertical-blank rise that exercises the pending restart.

// File: rtl/sle_pkg.sv
package sle_pkg;
  localparam int WORD_W  = 10;
  localparam int TRS_LEN = 4;
  localparam int LN_W    = 11;
  localparam int IDX_W   = 3;

  localparam logic [WORD_W-1:0] PRE_ONES = 10'h3FF;
  localparam logic [WORD_W-1:0] PRE_ZERO = 10'h000;

  typedef enum logic [1:0] {
    INS_NONE = 2'd0,
    INS_EAV  = 2'd1,
    INS_SAV  = 2'd2
  } ins_kind_e;

  typedef struct packed {
    logic hb;
    logic vb;
    logic fld;
  } sync_s;

  // Timing reference status word with protection bits.
  function automatic logic [WORD_W-1:0] xyz_word(input logic f, input logic v, input logic h);
    logic [3:0] prot;
    prot = {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    return {1'b1, f, v, h, prot, 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] ln_low_word(input logic [LN_W-1:0] ln);
    return {~ln[6], ln[6:0], 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] ln_high_word(input logic [LN_W-1:0] ln);
    return {1'b1, 3'b000, ln[10:7], 2'b00};
  endfunction

  // Index of the last word of an inserted sequence.
  function automatic logic [IDX_W-1:0] seq_last(input ins_kind_e kind, input logic hd);
    return (kind == INS_EAV && hd) ? IDX_W'(TRS_LEN + 1) : IDX_W'(TRS_LEN - 1);
  endfunction
endpackage

// File: rtl/sle_timing_detect.sv
module sle_timing_detect
  import sle_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      interlaced,
  input  logic [LANES*WORD_W-1:0]   in_data,
  input  sync_s                     in_sync,
  output logic [LANES*WORD_W-1:0]   tap_data,
  output sync_s                     tap_sync,
  output logic                      eav_start,
  output logic                      sav_start,
  output logic                      frame_hit
);
  localparam int DW = LANES * WORD_W;

  logic [DW-1:0] dly_data [TRS_LEN];
  sync_s         dly_sync [TRS_LEN];
  sync_s         prev_tap;
  logic          armed;
  logic          vb_rise;
  logic          fld_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TRS_LEN; k++) begin
        dly_data[k] <= '0;
        dly_sync[k] <= '0;
      end
      prev_tap <= '0;
      armed    <= 1'b0;
    end else begin
      dly_data[0] <= in_data;
      dly_sync[0] <= in_sync;
      for (int k = 1; k < TRS_LEN; k++) begin
        dly_data[k] <= dly_data[k-1];
        dly_sync[k] <= dly_sync[k-1];
      end
      prev_tap <= dly_sync[TRS_LEN-1];
      armed    <= (armed | fld_fall) & ~frame_hit;
    end
  end

  assign tap_data  = dly_data[TRS_LEN-1];
  assign tap_sync  = dly_sync[TRS_LEN-1];

  assign vb_rise   = tap_sync.vb & ~prev_tap.vb;
  assign fld_fall  = ~tap_sync.fld & prev_tap.fld;
  assign frame_hit = vb_rise & (~interlaced | armed | fld_fall);

  // End reference starts on the first blanking sample at the tap.
  assign eav_start = tap_sync.hb & ~prev_tap.hb;
  // Start reference: the sample now entering is the first active one,
  // so the tap holds the sample four places earlier.
  assign sav_start = dly_sync[0].hb & ~in_sync.hb;
endmodule

// File: rtl/sle_line_counter.sv
module sle_line_counter
  import sle_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eav_start,
  input  logic             frame_hit,
  output logic [LN_W-1:0]  line_cnt,
  output logic             restart
);
  logic pending;

  assign restart = pending | frame_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt <= '0;
      pending  <= 1'b0;
    end else if (eav_start) begin
      line_cnt <= restart ? LN_W'(1) : line_cnt + LN_W'(1);
      pending  <= 1'b0;
    end else begin
      pending  <= restart;
    end
  end
endmodule

// File: rtl/sle_insert_seq.sv
module sle_insert_seq
  import sle_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hd_mode,
  input  logic             eav_start,
  input  logic             sav_start,
  input  logic             eav_f,
  input  logic             eav_v,
  input  logic             sav_f,
  input  logic             sav_v,
  output ins_kind_e        cur_kind,
  output logic [IDX_W-1:0] cur_idx,
  output logic             cur_f,
  output logic             cur_v
);
  ins_kind_e        run_kind;
  logic [IDX_W-1:0] run_idx;
  logic             run_f;
  logic             run_v;

  always_comb begin
    if (eav_start) begin
      cur_kind = INS_EAV;
      cur_idx  = '0;
      cur_f    = eav_f;
      cur_v    = eav_v;
    end else if (sav_start) begin
      cur_kind = INS_SAV;
      cur_idx  = '0;
      cur_f    = sav_f;
      cur_v    = sav_v;
    end else begin
      cur_kind = run_kind;
      cur_idx  = run_idx;
      cur_f    = run_f;
      cur_v    = run_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_kind <= INS_NONE;
      run_idx  <= '0;
      run_f    <= 1'b0;
      run_v    <= 1'b0;
    end else begin
      if (cur_kind != INS_NONE && cur_idx != seq_last(cur_kind, hd_mode)) begin
        run_kind <= cur_kind;
        run_idx  <= cur_idx + IDX_W'(1);
      end else begin
        run_kind <= INS_NONE;
        run_idx  <= '0;
      end
      run_f <= cur_f;
      run_v <= cur_v;
    end
  end
endmodule

// File: rtl/sle_lane_mux.sv
module sle_lane_mux
  import sle_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [LANES*WORD_W-1:0] tap_data,
  input  ins_kind_e               cur_kind,
  input  logic [IDX_W-1:0]        cur_idx,
  input  logic                    cur_f,
  input  logic                    cur_v,
  input  logic [LN_W-1:0]         line_cnt,
  output logic [LANES*WORD_W-1:0] mux_data
);
  logic [WORD_W-1:0] ins_word;
  logic              ins_en;

  always_comb begin
    ins_en = (cur_kind != INS_NONE);
    case (cur_idx)
      3'd0:    ins_word = PRE_ONES;
      3'd1:    ins_word = PRE_ZERO;
      3'd2:    ins_word = PRE_ZERO;
      3'd3:    ins_word = xyz_word(cur_f, cur_v, cur_kind == INS_EAV);
      3'd4:    ins_word = ln_low_word(line_cnt);
      3'd5:    ins_word = ln_high_word(line_cnt);
      default: ins_word = PRE_ZERO;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mux_data[g*WORD_W +: WORD_W] = ins_en ? ins_word : tap_data[g*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/sle_embedder.sv
module sle_embedder
  import sle_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    interlaced,
  input  logic                    hd_mode,
  input  logic [LANES*WORD_W-1:0] vin_data,
  input  logic                    vin_hblank,
  input  logic                    vin_vblank,
  input  logic                    vin_field,
  output logic [LANES*WORD_W-1:0] vout_data,
  output logic                    vout_eav,
  output logic                    vout_sav
);
  localparam int DW = LANES * WORD_W;

  sync_s            in_sync;
  logic [DW-1:0]    tap_data;
  sync_s            tap_sync;
  logic             eav_start;
  logic             sav_start;
  logic             frame_hit;
  logic             frame_restart;
  logic [LN_W-1:0]  line_cnt;
  ins_kind_e        cur_kind;
  logic [IDX_W-1:0] cur_idx;
  logic             cur_f;
  logic             cur_v;
  logic [DW-1:0]    mux_data;

  assign in_sync = '{hb: vin_hblank, vb: vin_vblank, fld: vin_field};

  sle_timing_detect #(.LANES(LANES)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .interlaced(interlaced),
    .in_data   (vin_data),
    .in_sync   (in_sync),
    .tap_data  (tap_data),
    .tap_sync  (tap_sync),
    .eav_start (eav_start),
    .sav_start (sav_start),
    .frame_hit (frame_hit)
  );

  sle_line_counter u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .eav_start(eav_start),
    .frame_hit(frame_hit),
    .line_cnt (line_cnt),
    .restart  (frame_restart)
  );

  sle_insert_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hd_mode  (hd_mode),
    .eav_start(eav_start),
    .sav_start(sav_start),
    .eav_f    (tap_sync.fld),
    .eav_v    (tap_sync.vb),
    .sav_f    (vin_field),
    .sav_v    (vin_vblank),
    .cur_kind (cur_kind),
    .cur_idx  (cur_idx),
    .cur_f    (cur_f),
    .cur_v    (cur_v)
  );

  sle_lane_mux #(.LANES(LANES)) u_mux (
    .tap_data(tap_data),
    .cur_kind(cur_kind),
    .cur_idx (cur_idx),
    .cur_f   (cur_f),
    .cur_v   (cur_v),
    .line_cnt(line_cnt),
    .mux_data(mux_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vout_data <= '0;
      vout_eav  <= 1'b0;
      vout_sav  <= 1'b0;
    end else begin
      vout_data <= mux_data;
      vout_eav  <= (cur_kind == INS_EAV) && (cur_idx == IDX_W'(TRS_LEN - 1));
      vout_sav  <= (cur_kind == INS_SAV) && (cur_idx == IDX_W'(TRS_LEN - 1));
    end
  end
endmodule

// File: rtl/sle_embedder_chk.sv
module sle_embedder_chk
  import sle_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    hd_mode,
  input logic [LANES*WORD_W-1:0] vout_data,
  input logic                    vout_eav,
  input logic                    vout_sav,
  input logic [LANES*WORD_W-1:0] tap_data,
  input ins_kind_e               cur_kind,
  input logic                    eav_start,
  input logic                    frame_restart,
  input logic [LN_W-1:0]         line_cnt
);
  logic [WORD_W-1:0] w0;
  assign w0 = vout_data[WORD_W-1:0];

  p_pass_through_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cur_kind == INS_NONE |=> vout_data == $past(tap_data));

  p_eav_sequence_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vout_eav |-> w0[6] && $past(w0, 3) == PRE_ONES && $past(w0, 2) == PRE_ZERO && $past(w0, 1) == PRE_ZERO);

  p_xyz_protect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vout_eav || vout_sav) |-> w0[9] && w0[5] == (w0[7] ^ w0[6]) && w0[4] == (w0[8] ^ w0[6])
      && w0[3] == (w0[8] ^ w0[7]) && w0[2] == (w0[8] ^ w0[7] ^ w0[6]) && w0[1:0] == 2'b00);

  p_sav_sequence_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vout_sav |-> !w0[6] && $past(w0, 3) == PRE_ONES && $past(w0, 2) == PRE_ZERO && $past(w0, 1) == PRE_ZERO);

  p_ln_word_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hd_mode && $past(vout_eav) |-> w0[9] == ~w0[8] && w0[1:0] == 2'b00);

  p_line_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eav_start && !frame_restart |=> line_cnt == $past(line_cnt) + LN_W'(1));

  p_line_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !eav_start |=> $stable(line_cnt));

  p_line_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eav_start && frame_restart |=> line_cnt == LN_W'(1));

  p_markers_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(vout_eav && vout_sav));
endmodule

bind sle_embedder sle_embedder_chk #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hd_mode      (hd_mode),
  .vout_data    (vout_data),
  .vout_eav     (vout_eav),
  .vout_sav     (vout_sav),
  .tap_data     (tap_data),
  .cur_kind     (cur_kind),
  .eav_start    (eav_start),
  .frame_restart(frame_restart),
  .line_cnt     (line_cnt)
);

// File: tb/sle_embedder_test.sv
module sle_embedder_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 2;
  localparam int DW = LANES * 10;
  localparam int MAXS = 4096;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic interlaced = 1'b0;
  logic hd_mode = 1'b0;
  logic [DW-1:0] vin_data = '0;
  logic vin_hblank = 1'b0, vin_vblank = 1'b0, vin_field = 1'b0;
  logic [DW-1:0] vout_data;
  logic vout_eav, vout_sav;

  sle_embedder #(.LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .interlaced(interlaced), .hd_mode(hd_mode),
    .vin_data(vin_data), .vin_hblank(vin_hblank), .vin_vblank(vin_vblank), .vin_field(vin_field),
    .vout_data(vout_data), .vout_eav(vout_eav), .vout_sav(vout_sav)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Stream storage
  bit hb_a [MAXS];
  bit vb_a [MAXS];
  bit fd_a [MAXS];
  logic [DW-1:0] in_a  [MAXS];
  logic [DW-1:0] exp_d [MAXS];
  bit exp_e [MAXS];
  bit exp_s [MAXS];
  string tag_a [MAXS];
  int n_samp = 0;
  bit last_vb = 1'b0;

  typedef struct { int due; int idx; } item_t;
  item_t sb_q [$];

  function automatic logic [9:0] sample_val(int i, int k);
    return 10'(((i * 7 + k * 53) % 900) + 40);
  endfunction

  task automatic add_line(int blank, int active, bit vb, bit fd, int vb_from);
    for (int p = 0; p < blank + active; p++) begin
      hb_a[n_samp] = (p < blank);
      vb_a[n_samp] = (p >= vb_from) ? vb : last_vb;
      fd_a[n_samp] = fd;
      for (int k = 0; k < LANES; k++) in_a[n_samp][k*10 +: 10] = sample_val(n_samp, k);
      last_vb = vb_a[n_samp];
      n_samp++;
    end
  endtask

  function automatic logic [DW-1:0] all_lanes(logic [9:0] w);
    logic [DW-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*10 +: 10] = w;
    return r;
  endfunction

  function automatic logic [9:0] ref_word(bit f, bit v, bit h);
    logic [9:0] r;
    r = '0;
    r[9] = 1'b1; r[8] = f; r[7] = v; r[6] = h;
    r[2] = f ^ v ^ h; r[3] = f ^ v; r[4] = f ^ h; r[5] = v ^ h;
    return r;
  endfunction

  task automatic compute_expected(bit il, bit hd, string ln_tag);
    bit hbp, vbp, fdp, armed, pending, hit;
    logic [10:0] cnt;
    hbp = 0; vbp = 0; fdp = 0; armed = 0; pending = 0; cnt = '0;
    for (int i = 0; i < n_samp; i++) begin
      exp_d[i] = in_a[i]; exp_e[i] = 0; exp_s[i] = 0; tag_a[i] = "R1";
    end
    for (int i = 0; i < n_samp; i++) begin
      hit = vb_a[i] && !vbp && (!il || armed || (!fd_a[i] && fdp));
      armed = (armed || (!fd_a[i] && fdp)) && !hit;
      if (hb_a[i] && !hbp) begin
        cnt = (pending || hit) ? 11'd1 : cnt + 11'd1;
        pending = 0;
        if (i + 3 < n_samp) begin
          exp_d[i]   = all_lanes(10'h3FF); tag_a[i]   = "R2";
          exp_d[i+1] = all_lanes(10'h000); tag_a[i+1] = "R2";
          exp_d[i+2] = all_lanes(10'h000); tag_a[i+2] = "R2";
          exp_d[i+3] = all_lanes(ref_word(fd_a[i], vb_a[i], 1'b1)); tag_a[i+3] = "R3";
          exp_e[i+3] = 1;
        end
        if (i + 5 < n_samp) begin
          if (hd) begin
            exp_d[i+4] = all_lanes({~cnt[6], cnt[6:0], 2'b00});
            exp_d[i+5] = all_lanes({4'b1000, cnt[10:7], 2'b00});
            tag_a[i+4] = {"R5 ", ln_tag}; tag_a[i+5] = {"R5 ", ln_tag};
          end else begin
            tag_a[i+4] = "R5 sd"; tag_a[i+5] = "R5 sd";
          end
        end
      end else begin
        pending = pending || hit;
      end
      if (!hb_a[i] && hbp && i >= 4) begin
        exp_d[i-4] = all_lanes(10'h3FF); tag_a[i-4] = "R4";
        exp_d[i-3] = all_lanes(10'h000); tag_a[i-3] = "R4";
        exp_d[i-2] = all_lanes(10'h000); tag_a[i-2] = "R4";
        exp_d[i-1] = all_lanes(ref_word(fd_a[i], vb_a[i], 1'b0)); tag_a[i-1] = "R3";
        exp_s[i-1] = 1;
      end
      hbp = hb_a[i]; vbp = vb_a[i]; fdp = fd_a[i];
    end
  endtask

  task automatic do_reset(bit il, bit hd);
    @(negedge clk);
    rst_n = 1'b0;
    vin_data = '0; vin_hblank = 0; vin_vblank = 0; vin_field = 0;
    interlaced = il; hd_mode = hd;
    repeat (3) @(negedge clk);
    checks++;
    if (vout_data !== '0 || vout_eav !== 1'b0 || vout_sav !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: actual=%h/%b/%b expected=0/0/0", vout_data, vout_eav, vout_sav);
    end
    rst_n = 1'b1;
  endtask

  task automatic run_case(bit il, bit hd, string ln_tag);
    compute_expected(il, hd, ln_tag);
    do_reset(il, hd);
    for (int i = 0; i < n_samp; i++) begin
      @(negedge clk);
      vin_data = in_a[i]; vin_hblank = hb_a[i]; vin_vblank = vb_a[i]; vin_field = fd_a[i];
      sb_q.push_back('{due: cyc + LAT, idx: i});
    end
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      vin_data = all_lanes(10'(p + 200));
    end
    wait (sb_q.size() == 0);
    n_samp = 0;
    last_vb = 0;
  endtask

  // Monitor: compare output against the scoreboard front.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (vout_data !== exp_d[it.idx]) begin
          errors++;
          $display("FAIL %s sample %0d: actual=%h expected=%h", tag_a[it.idx], it.idx, vout_data, exp_d[it.idx]);
        end
        checks++;
        if (vout_eav !== exp_e[it.idx] || vout_sav !== exp_s[it.idx]) begin
          errors++;
          $display("FAIL R10 sample %0d: actual eav/sav=%b%b expected=%b%b", it.idx, vout_eav, vout_sav,
                   exp_e[it.idx], exp_s[it.idx]);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Progressive HD, including a mid-line vblank rise (R7)
    add_line(12, 20, 0, 0, 0);
    add_line(12, 20, 0, 0, 0);
    for (int l = 0; l < 8; l++) add_line(12, 20, l < 2, 0, 0);
    add_line(12, 20, 0, 0, 0);
    add_line(12, 20, 1, 0, 20);
    for (int l = 0; l < 4; l++) add_line(12, 20, 0, 0, 0);
    run_case(1'b0, 1'b1, "R7");

    // Interlaced HD: field-1 vblank must not restart (R8)
    add_line(12, 20, 0, 1, 0);
    for (int l = 0; l < 5; l++) add_line(12, 20, l < 2, 0, 0);
    for (int l = 0; l < 5; l++) add_line(12, 20, l < 2, 1, 0);
    for (int l = 0; l < 5; l++) add_line(12, 20, l < 2, 0, 0);
    run_case(1'b1, 1'b1, "R8");

    // Progressive SD: line-number positions pass through (R5)
    for (int l = 0; l < 6; l++) add_line(10, 6, l == 1, 0, 0);
    run_case(1'b0, 1'b0, "R5");

    // Long run crossing line 128 to reach the upper line bits (R6)
    for (int l = 0; l < 140; l++) add_line(12, 4, 0, 0, 0);
    run_case(1'b0, 1'b1, "R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule